// File: doc/BRIEF.md
# Serial Audio Link Reset and Wake Sequencer

This block sits on the controller side of a serial audio codec link. It takes the link out of power-down and issues the two kinds of link reset. It runs from the system clock and drives the link reset line and the wake pulse on the frame-sync line. It also watches two things: activity on the codec's bit clock, and the codec-ready flag that the frame receiver extracts from the incoming tag slot.

Software or a power manager sends one of three commands: cold reset, warm reset or power-down notice. A cold reset holds the link reset low for a fixed time. A warm reset raises the frame-sync line, but only after the bit clock has gone quiet and only once the post-power-down gap has passed. After either reset, the block waits for a bit-clock edge that arrives after frame-sync is low again. It also waits for the ready flag. It then emits a one-cycle `done` and hands the frame-sync line to the normal frame engine through `sync_sel`.

A sequence that does not reach readiness in time raises `err` and returns the block to idle.

Top module: `aclink_wake_seq`

## Requirements
- R1: An accepted cold command (op 01) drives `link_rst_n` low for exactly RST_LOW_CYC system clocks, whatever the bit clock is doing, and sets `last_kind` to 01.
- R2: An accepted warm command (op 10) sets `last_kind` to 10. It then raises `sync_out` only once the bit clock is absent, meaning no edge for IDLE_CYC clocks. `sync_out` then stays high for exactly WARM_HI_CYC clocks.
- R3: After the warm pulse, `sync_out` is low. Readiness needs a bit-clock edge seen after that fall; a ready flag alone with a silent bit clock is not enough.
- R4: After an accepted power-down command (op 11), `sync_out` does not rise within HOLDOFF_CYC clocks. A warm command given during this gap is held and performed once the gap ends.
- R5: Readiness is declared only while `codec_rdy` (input slot 0, bit 15) is 1. At that point `done` pulses for one clock, `sync_sel` goes to 1, and `sync_out` stays low.
- R6: A command is accepted only when `cmd_valid` is 1, `busy` is 0 and the op is not 00. A command given while `busy` is 1, or with op 00, changes nothing.
- R7: If readiness is not reached within TIMEOUT_CYC clocks of waiting, `err` is set and the block returns to idle with `busy` 0. The next accepted command clears `err`.
- R8: An accepted power-down command drops `sync_sel` to 0 and leaves `busy` at 0.
- R9: After system reset: `busy`, `done`, `err`, `sync_out` and `sync_sel` are 0, `link_rst_n` is 1 and `last_kind` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 01 cold, 10 warm, 11 power-down, 00 none |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the link is ready |
| err | output | 1 | Readiness timeout flag |
| last_kind | output | 2 | Last reset started: 00 none, 01 cold, 10 warm |
| link_rst_n | output | 1 | Link reset line, active low |
| sync_out | output | 1 | Wake pulse on the frame-sync line |
| sync_sel | output | 1 | 1 hands frame-sync to the frame engine |
| bitclk_in | input | 1 | Codec bit clock, asynchronous |
| codec_rdy | input | 1 | Ready flag from input slot 0, bit 15 |

## Verification
The bench checks the cold path in three ways:
- It measures the exact length of the reset pulse.
- It sends a warm command while the sequence is still busy, to show that the command is dropped.
- It keeps the ready flag low for a while with the bit clock running, to show the ready flag gates completion.

The wake path is run straight after a power-down notice. This measures the hold-off gap and the pulse width. The ready flag is then held high while the bit clock stays silent, which separates "flag seen" from "flag seen after a fresh clock edge".

Two failure patterns are also tried:
- A warm request while the bit clock keeps running. This must never pulse frame-sync and must end in a timeout.
- A cold reset whose bit clock never starts.

// File: rtl/aclink_wake_seq.sv
module aclink_wake_seq #(
  parameter int RST_LOW_CYC = 8,
  parameter int WARM_HI_CYC = 6,
  parameter int HOLDOFF_CYC = 40,
  parameter int IDLE_CYC    = 6,
  parameter int TIMEOUT_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [1:0] last_kind,
  output logic       link_rst_n,
  output logic       sync_out,
  output logic       sync_sel,
  input  logic       bitclk_in,
  input  logic       codec_rdy
);
  localparam int M1 = (RST_LOW_CYC > WARM_HI_CYC) ? RST_LOW_CYC : WARM_HI_CYC;
  localparam int TMAX = (M1 > TIMEOUT_CYC) ? M1 : TIMEOUT_CYC;
  localparam int TW = $clog2(TMAX + 1);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);

  typedef enum logic [2:0] {S_OFF, S_COLD, S_WHOLD, S_WHI, S_WAIT, S_RDY} st_t;
  st_t st;

  logic bc_s1, bc_s2, bc_d, edge_seen;
  logic [IW-1:0] idle_cnt;
  logic [HW-1:0] hold_cnt;
  logic [TW-1:0] tmr;

  wire bc_edge   = bc_s2 ^ bc_d;
  wire bc_absent = (idle_cnt == IW'(IDLE_CYC));
  wire tmo       = (tmr == TW'(TIMEOUT_CYC - 1));
  assign busy = (st != S_OFF) && (st != S_RDY);
  wire take = cmd_valid && !busy && (cmd_op != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {bc_s1, bc_s2, bc_d} <= '0;
      idle_cnt <= IW'(IDLE_CYC);
    end else begin
      bc_s1 <= bitclk_in;
      bc_s2 <= bc_s1;
      bc_d  <= bc_s2;
      if (bc_edge) idle_cnt <= '0;
      else if (!bc_absent) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      done <= 1'b0;
      err <= 1'b0;
      last_kind <= 2'b00;
      link_rst_n <= 1'b1;
      sync_out <= 1'b0;
      sync_sel <= 1'b0;
      hold_cnt <= '0;
      tmr <= '0;
      edge_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      case (st)
        S_OFF, S_RDY: if (take) begin
          err <= 1'b0;
          sync_sel <= 1'b0;
          case (cmd_op)
            2'b01: begin
              st <= S_COLD;
              link_rst_n <= 1'b0;
              tmr <= TW'(RST_LOW_CYC - 1);
              last_kind <= 2'b01;
              hold_cnt <= '0;
            end
            2'b10: begin
              st <= S_WHOLD;
              tmr <= '0;
              last_kind <= 2'b10;
            end
            default: begin
              st <= S_OFF;
              hold_cnt <= HW'(HOLDOFF_CYC);
            end
          endcase
        end
        S_COLD: if (tmr == '0) begin
          link_rst_n <= 1'b1;
          st <= S_WAIT;
          edge_seen <= 1'b0;
        end else tmr <= tmr - 1'b1;
        S_WHOLD: if (hold_cnt == '0) begin
          if (bc_absent) begin
            sync_out <= 1'b1;
            st <= S_WHI;
            tmr <= TW'(WARM_HI_CYC - 1);
          end else if (tmo) begin
            err <= 1'b1;
            st <= S_OFF;
          end else tmr <= tmr + 1'b1;
        end
        S_WHI: if (tmr == '0) begin
          sync_out <= 1'b0;
          st <= S_WAIT;
          edge_seen <= 1'b0;
        end else tmr <= tmr - 1'b1;
        S_WAIT: begin
          if (bc_edge) edge_seen <= 1'b1;
          if (edge_seen && codec_rdy) begin
            done <= 1'b1;
            sync_sel <= 1'b1;
            st <= S_RDY;
          end else if (tmo) begin
            err <= 1'b1;
            st <= S_OFF;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

module aclink_wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] last_kind,
  input logic       link_rst_n,
  input logic       sync_out,
  input logic       sync_sel,
  input logic       codec_rdy,
  input logic       bc_absent,
  input logic       hold_zero
);
  p_cold_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rst_n |-> last_kind == 2'b01);
  p_warm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(bc_absent));
  p_warm_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> last_kind == 2'b10);
  p_holdoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(hold_zero));
  p_done_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(codec_rdy));
  p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_sel |-> !sync_out);
  p_busy_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sync_sel);
  p_err_nodone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !done && !sync_sel && !busy);
endmodule

bind aclink_wake_seq aclink_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .last_kind(last_kind), .link_rst_n(link_rst_n), .sync_out(sync_out),
  .sync_sel(sync_sel), .codec_rdy(codec_rdy), .bc_absent(bc_absent),
  .hold_zero(hold_cnt == '0)
);

// File: tb/aclink_wake_seq_bench.sv
module aclink_wake_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RSTL = 8, WHI = 6, HOLD = 40, IDLE = 6, TMO = 100;

  logic clk = 0, rst_n = 0, cmd_valid = 0, bitclk_in = 0, codec_rdy = 0, bc_en = 0;
  logic [1:0] cmd_op = 2'b00;
  logic busy, done, err, link_rst_n, sync_out, sync_sel;
  logic [1:0] last_kind;
  int n_run = 0, n_fail = 0, bc_div = 0;
  bit ended = 0;
  logic [2:0] exp_q[$];
  logic err_q = 0;

  aclink_wake_seq #(.RST_LOW_CYC(RSTL), .WARM_HI_CYC(WHI), .HOLDOFF_CYC(HOLD),
    .IDLE_CYC(IDLE), .TIMEOUT_CYC(TMO)) u_aclink_wake_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
    .done(done), .err(err), .last_kind(last_kind), .link_rst_n(link_rst_n),
    .sync_out(sync_out), .sync_sel(sync_sel), .bitclk_in(bitclk_in), .codec_rdy(codec_rdy));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (bc_en) begin
      bc_div = bc_div + 1;
      if (bc_div == 2) begin bitclk_in = ~bitclk_in; bc_div = 0; end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each done pulse or err rise pops one expected item {is_err, last_kind}
  always @(negedge clk) begin
    if (rst_n) begin
      if (done || (err && !err_q)) begin
        if (exp_q.size() == 0) chk("R5/R7 unexpected completion", {done, err}, 0);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk("R5/R7 completion kind", {err, last_kind}, e);
        end
      end
      err_q = err;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [1:0] op);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b00;
  endtask

  task automatic wait_sel();
    for (int i = 0; i < 300 && !sync_sel; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int cnt;
    cyc(3);
    // R9 reset state
    chk("R9 busy", busy, 0); chk("R9 sync_sel", sync_sel, 0); chk("R9 link_rst_n", link_rst_n, 1);
    chk("R9 sync_out", sync_out, 0); chk("R9 last_kind", last_kind, 0); chk("R9 err", err, 0);
    rst_n = 1; cyc(2);

    // R1 cold reset pulse length, bit clock silent
    send(2'b01);
    chk("R6 busy after cold", busy, 1);
    cnt = 0;
    while (!link_rst_n && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R1 reset low cycles", cnt, RSTL);
    chk("R1 last_kind cold", last_kind, 2'b01);
    // R6 warm while busy is dropped
    send(2'b10);
    cyc(2);
    chk("R6 busy cmd ignored kind", last_kind, 2'b01);
    chk("R6 busy cmd ignored sync", sync_out, 0);
    // R5 ready flag gates completion
    bc_en = 1; cyc(30);
    chk("R5 no ready without flag", sync_sel, 0);
    exp_q.push_back(3'b001);
    codec_rdy = 1;
    wait_sel();
    chk("R5 sync_sel after cold", sync_sel, 1);
    // R6 op 00 has no effect
    send(2'b00); cyc(2);
    chk("R6 op00 sel kept", sync_sel, 1);
    chk("R6 op00 not busy", busy, 0);

    // R8 / R4 power-down then early warm
    send(2'b11);
    bc_en = 0; codec_rdy = 0;
    chk("R8 sel dropped", sync_sel, 0);
    chk("R8 not busy", busy, 0);
    send(2'b10);
    cnt = 2;
    while (!sync_out && cnt < 300) begin cnt++; @(negedge clk); end
    chk("R4 holdoff respected", cnt >= HOLD, 1);
    chk("R2 last_kind warm", last_kind, 2'b10);
    cnt = 0;
    while (sync_out && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R2 wake pulse cycles", cnt, WHI);
    // R3 flag set but bit clock silent
    codec_rdy = 1; cyc(20);
    chk("R3 no ready without fresh edge", sync_sel, 0);
    exp_q.push_back(3'b010);
    bc_en = 1;
    wait_sel();
    chk("R3 ready after edge", sync_sel, 1);

    // R2 / R7 warm while bit clock keeps running
    send(2'b10);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin cnt += sync_out; @(negedge clk); end
    chk("R2 no pulse with clock running", cnt, 0);
    exp_q.push_back(3'b110);
    for (int i = 0; i < 200 && !err; i++) @(negedge clk);
    chk("R7 err after timeout", err, 1);
    chk("R7 idle after timeout", busy, 0);

    // R7 cold with no bit clock, err cleared on accept
    bc_en = 0; cyc(10);
    send(2'b01);
    chk("R7 err cleared on accept", err, 0);
    exp_q.push_back(3'b101);
    for (int i = 0; i < 300 && !err; i++) @(negedge clk);
    chk("R7 cold timeout err", err, 1);
    cyc(3);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule